// File: doc/BRIEF.md
# Management-Bus PHY Address Scanner

This block searches a management bus for the first attached PHY. A one-cycle start pulse begins the search. The block then visits the 32 PHY addresses in turn, starting at address 0. At each address it issues two register reads through a simple request/response port to an external MDIO master, which generates the serial frames. It fetches the first identifier word (register 2) and then the second (register 3).

Each pair of identifier words is screened. Values that an empty or broken bus typically returns are rejected: all zeros, all ones, and the single-bit pattern 0x8000. The first address whose pair passes ends the search.

When the search ends, the block raises a one-cycle done pulse and presents its result, which then holds until a later search replaces it. The result is a found flag, the address, both identifier words, and a two-bit type code. The type code comes from masked comparisons that ignore the revision nibble of the second word.

Top module: `phy_scan_top`

## Requirements
- R1: Addresses are visited in ascending order, starting at 0 and ending at 31. The search stops at the lowest address that passes the screen, and no read is issued to any higher address.
- R2: At every visited address, register 2 is read first and register 3 second. Both reads of a pair target the same address.
- R3: An address passes only when each of its two identifier words lies in the range 0x0001 to 0xFFFE inclusive.
- R4: An address fails when either identifier word equals 0x8000, even though that value lies inside the range of R3.
- R5: If none of the 32 addresses passes, the block performs exactly 64 reads. It then reports found_o = 0, with phy_addr_o, id1_o, id2_o and kind_o all zero.
- R6: kind_o = 1 when id1 equals 0x0016 and (id2 AND 0xFFF0) equals 0xF840.
- R7: kind_o = 2 when id1 equals 0x0282 and (id2 AND 0xFFF0) equals 0x1C50. Any other passing PHY gives kind_o = 3.
- R8: At most one read is outstanding at any time. rd_req_o, rd_phy_o and rd_reg_o hold steady from the moment a request is raised until rd_done_i is seen. The word on rd_data_i is taken only in the cycle that rd_done_i is high.
- R9: done_o is high for exactly one cycle, in the first cycle that busy_o is low after a search. The result outputs then stay constant until a later search finishes. A start pulse that arrives while busy_o is high is ignored.
- R10: After reset, busy_o, done_o, found_o, rd_req_o, phy_addr_o, id1_o, id2_o and kind_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a search when the block is idle |
| rd_req_o | output | 1 | Read request to the MDIO master; held until rd_done_i |
| rd_phy_o | output | 5 | PHY address of the current read |
| rd_reg_o | output | 5 | Register number of the current read (2 or 3) |
| rd_done_i | input | 1 | One-cycle completion pulse from the MDIO master |
| rd_data_i | input | 16 | Read data, valid while rd_done_i is high |
| busy_o | output | 1 | High while a search is in progress |
| done_o | output | 1 | One-cycle pulse when a result is published |
| found_o | output | 1 | A PHY passed the screen |
| phy_addr_o | output | 5 | Address of the PHY found |
| id1_o | output | 16 | First identifier word of the PHY found |
| id2_o | output | 16 | Second identifier word of the PHY found |
| kind_o | output | 2 | 0 none, 1 first known type, 2 second known type, 3 unknown |

## Verification
The bench models the MDIO master with a per-address table of identifier words and a configurable response latency. The tables cover several cases:
- An empty bus (all 0xFFFF), which tells a full 64-read sweep apart from an early stop.
- A bus where the lower addresses return 0x0000, 0x8000 in either word, or only one good word, before a real PHY. This separates each rejection rule from the others.
- Two passing PHYs, which shows the stop happens at the lower address.
- Identifier values at 0x0001, 0xFFFE and just beside 0x8000, plus words that match a known type only in the masked nibble or miss it in the unmasked part. These pin down the range limits and the type mask.

A second start pulse in the middle of a long search, with a slow master, shows whether the read order is disturbed.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

    localparam int PHY_ADDR_W = 5;
    localparam int REG_ADDR_W = 5;
    localparam int ID_W       = 16;
    localparam int NUM_PHY    = 1 << PHY_ADDR_W;

    typedef logic [PHY_ADDR_W-1:0] phy_addr_t;
    typedef logic [REG_ADDR_W-1:0] reg_addr_t;
    typedef logic [ID_W-1:0]       id_word_t;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_ALPHA = 2'd1,
        KIND_BETA  = 2'd2,
        KIND_OTHER = 2'd3
    } phy_kind_e;

    typedef struct packed {
        logic      found;
        phy_addr_t addr;
        id_word_t  id1;
        id_word_t  id2;
        phy_kind_e kind;
    } scan_result_t;

    localparam phy_addr_t LAST_PHY   = phy_addr_t'(NUM_PHY - 1);
    localparam reg_addr_t ID1_REG    = reg_addr_t'(2);
    localparam reg_addr_t ID2_REG    = reg_addr_t'(3);

    localparam id_word_t  ID_BLANK   = '0;
    localparam id_word_t  ID_FLOAT   = '1;
    localparam id_word_t  ID_STUCK   = id_word_t'(16'h8000);
    localparam id_word_t  REV_MASK   = id_word_t'(16'hFFF0);
    localparam id_word_t  ALPHA_ID1  = id_word_t'(16'h0016);
    localparam id_word_t  ALPHA_ID2  = id_word_t'(16'hF840);
    localparam id_word_t  BETA_ID1   = id_word_t'(16'h0282);
    localparam id_word_t  BETA_ID2   = id_word_t'(16'h1C50);

    // A single identifier word is plausible when it is neither an idle
    // bus value nor the stuck single-bit pattern.
    function automatic logic id_word_ok(input id_word_t w);
        return (w > ID_BLANK) && (w < ID_FLOAT) && (w != ID_STUCK);
    endfunction

    function automatic phy_kind_e classify(input id_word_t id1, input id_word_t id2);
        phy_kind_e k;
        k = KIND_OTHER;
        if ((id1 == ALPHA_ID1) && ((id2 & REV_MASK) == ALPHA_ID2))
            k = KIND_ALPHA;
        else if ((id1 == BETA_ID1) && ((id2 & REV_MASK) == BETA_ID2))
            k = KIND_BETA;
        return k;
    endfunction

endpackage

// File: rtl/phy_id_judge.sv
module phy_id_judge
    import phy_scan_pkg::*;
#(
    parameter int N_WORDS = 2
) (
    input  id_word_t  id1_i,
    input  id_word_t  id2_i,
    output logic      ok_o,
    output phy_kind_e kind_o
);

    id_word_t             words [N_WORDS];
    logic [N_WORDS-1:0]   word_ok;

    assign words[0] = id1_i;
    assign words[1] = id2_i;

    // Screen each identifier word with the same rule.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_screen
        assign word_ok[g] = id_word_ok(words[g]);
    end

    assign ok_o   = &word_ok;
    assign kind_o = ok_o ? classify(id1_i, id2_i) : KIND_NONE;

endmodule

// File: rtl/phy_scan_ctrl.sv
module phy_scan_ctrl
    import phy_scan_pkg::*;
#(
    parameter reg_addr_t FIRST_REG  = ID1_REG,
    parameter reg_addr_t SECOND_REG = ID2_REG
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      rd_done_i,
    input  id_word_t  rd_data_i,
    input  logic      cand_ok_i,
    output logic      rd_req_o,
    output phy_addr_t rd_phy_o,
    output reg_addr_t rd_reg_o,
    output logic      busy_o,
    output id_word_t  cand_id1_o,
    output id_word_t  cand_id2_o,
    output logic      fin_o,
    output logic      fin_found_o,
    output phy_addr_t fin_addr_o
);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_EVAL = 2'd3
    } scan_state_e;

    scan_state_e state_q, state_d;
    phy_addr_t   addr_q,  addr_d;
    id_word_t    id1_q,   id1_d;
    id_word_t    id2_q,   id2_d;

    always_comb begin
        state_d     = state_q;
        addr_d      = addr_q;
        id1_d       = id1_q;
        id2_d       = id2_q;
        fin_o       = 1'b0;
        fin_found_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_RD1;
                    addr_d  = '0;
                end
            end
            ST_RD1: begin
                if (rd_done_i) begin
                    id1_d   = rd_data_i;
                    state_d = ST_RD2;
                end
            end
            ST_RD2: begin
                if (rd_done_i) begin
                    id2_d   = rd_data_i;
                    state_d = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (cand_ok_i) begin
                    fin_o       = 1'b1;
                    fin_found_o = 1'b1;
                    state_d     = ST_IDLE;
                end else if (addr_q == LAST_PHY) begin
                    fin_o       = 1'b1;
                    state_d     = ST_IDLE;
                end else begin
                    addr_d  = addr_q + phy_addr_t'(1);
                    state_d = ST_RD1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            id1_q   <= '0;
            id2_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            id1_q   <= id1_d;
            id2_q   <= id2_d;
        end
    end

    assign rd_req_o   = (state_q == ST_RD1) || (state_q == ST_RD2);
    assign rd_reg_o   = (state_q == ST_RD2) ? SECOND_REG : FIRST_REG;
    assign rd_phy_o   = addr_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign cand_id1_o = id1_q;
    assign cand_id2_o = id2_q;
    assign fin_addr_o = addr_q;

endmodule

// File: rtl/phy_scan_result.sv
module phy_scan_result
    import phy_scan_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         fin_i,
    input  logic         fin_found_i,
    input  phy_addr_t    fin_addr_i,
    input  id_word_t     id1_i,
    input  id_word_t     id2_i,
    input  phy_kind_e    kind_i,
    output scan_result_t res_o,
    output logic         done_o
);

    scan_result_t res_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin_i;
            if (fin_i) begin
                if (fin_found_i) begin
                    res_q.found <= 1'b1;
                    res_q.addr  <= fin_addr_i;
                    res_q.id1   <= id1_i;
                    res_q.id2   <= id2_i;
                    res_q.kind  <= kind_i;
                end else begin
                    res_q <= '0;
                end
            end
        end
    end

    assign res_o  = res_q;
    assign done_o = done_q;

endmodule

// File: rtl/phy_scan_top.sv
module phy_scan_top
    import phy_scan_pkg::*;
#(
    parameter reg_addr_t FIRST_REG  = ID1_REG,
    parameter reg_addr_t SECOND_REG = ID2_REG
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    output logic                  rd_req_o,
    output logic [PHY_ADDR_W-1:0] rd_phy_o,
    output logic [REG_ADDR_W-1:0] rd_reg_o,
    input  logic                  rd_done_i,
    input  logic [ID_W-1:0]       rd_data_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  found_o,
    output logic [PHY_ADDR_W-1:0] phy_addr_o,
    output logic [ID_W-1:0]       id1_o,
    output logic [ID_W-1:0]       id2_o,
    output logic [1:0]            kind_o
);

    id_word_t     cand_id1, cand_id2;
    logic         cand_ok;
    phy_kind_e    cand_kind;
    logic         fin, fin_found;
    phy_addr_t    fin_addr;
    scan_result_t res;

    phy_scan_ctrl #(
        .FIRST_REG  (FIRST_REG),
        .SECOND_REG (SECOND_REG)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rd_done_i   (rd_done_i),
        .rd_data_i   (rd_data_i),
        .cand_ok_i   (cand_ok),
        .rd_req_o    (rd_req_o),
        .rd_phy_o    (rd_phy_o),
        .rd_reg_o    (rd_reg_o),
        .busy_o      (busy_o),
        .cand_id1_o  (cand_id1),
        .cand_id2_o  (cand_id2),
        .fin_o       (fin),
        .fin_found_o (fin_found),
        .fin_addr_o  (fin_addr)
    );

    phy_id_judge #(
        .N_WORDS (2)
    ) u_judge (
        .id1_i  (cand_id1),
        .id2_i  (cand_id2),
        .ok_o   (cand_ok),
        .kind_o (cand_kind)
    );

    phy_scan_result u_result (
        .clk         (clk),
        .rst         (rst),
        .fin_i       (fin),
        .fin_found_i (fin_found),
        .fin_addr_i  (fin_addr),
        .id1_i       (cand_id1),
        .id2_i       (cand_id2),
        .kind_i      (cand_kind),
        .res_o       (res),
        .done_o      (done_o)
    );

    assign found_o    = res.found;
    assign phy_addr_o = res.addr;
    assign id1_o      = res.id1;
    assign id2_o      = res.id2;
    assign kind_o     = res.kind;

endmodule

// File: rtl/phy_scan_chk.sv
module phy_scan_chk
    import phy_scan_pkg::*;
#(
    parameter reg_addr_t FIRST_REG  = ID1_REG,
    parameter reg_addr_t SECOND_REG = ID2_REG
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  rd_req_o,
    input logic [PHY_ADDR_W-1:0] rd_phy_o,
    input logic [REG_ADDR_W-1:0] rd_reg_o,
    input logic                  rd_done_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  found_o,
    input logic [PHY_ADDR_W-1:0] phy_addr_o,
    input logic [ID_W-1:0]       id1_o,
    input logic [ID_W-1:0]       id2_o,
    input logic [1:0]            kind_o
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && !rd_done_i |=> rd_req_o && $stable(rd_phy_o) && $stable(rd_reg_o)); // R8

    AST_ID_ORDER: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && rd_done_i && (rd_reg_o == FIRST_REG)
        |=> rd_req_o && (rd_reg_o == SECOND_REG) && $stable(rd_phy_o)); // R2

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) && !$stable(rd_phy_o)
        |-> rd_phy_o == $past(rd_phy_o) + 5'd1); // R1

    AST_FOUND_RANGE: assert property (@(posedge clk) disable iff (rst)
        done_o && found_o |-> (id1_o != 16'h0000) && (id1_o != 16'hFFFF)
                            && (id2_o != 16'h0000) && (id2_o != 16'hFFFF)); // R3

    AST_NO_STUCK: assert property (@(posedge clk) disable iff (rst)
        done_o && found_o |-> (id1_o != 16'h8000) && (id2_o != 16'h8000)); // R4

    AST_NOTFOUND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done_o && !found_o |-> (kind_o == 2'd0) && (phy_addr_o == '0)
                             && (id1_o == '0) && (id2_o == '0)); // R5

    AST_KIND_ALPHA: assert property (@(posedge clk) disable iff (rst)
        done_o && found_o && (id1_o == 16'h0016) && ((id2_o & 16'hFFF0) == 16'hF840)
        |-> kind_o == 2'd1); // R6

    AST_KIND_BETA: assert property (@(posedge clk) disable iff (rst)
        done_o && found_o && (id1_o == 16'h0282) && ((id2_o & 16'hFFF0) == 16'h1C50)
        |-> kind_o == 2'd2); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && $past(busy_o)); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy_o && !$past(busy_o) |-> $stable(found_o) && $stable(phy_addr_o)
            && $stable(id1_o) && $stable(id2_o) && $stable(kind_o)); // R9

endmodule

bind phy_scan_top phy_scan_chk #(
    .FIRST_REG  (FIRST_REG),
    .SECOND_REG (SECOND_REG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_req_o   (rd_req_o),
    .rd_phy_o   (rd_phy_o),
    .rd_reg_o   (rd_reg_o),
    .rd_done_i  (rd_done_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .found_o    (found_o),
    .phy_addr_o (phy_addr_o),
    .id1_o      (id1_o),
    .id2_o      (id2_o),
    .kind_o     (kind_o)
);

// File: tb/tb_phy_scan_top.sv
module tb_phy_scan_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        rd_req_o;
    logic [4:0]  rd_phy_o;
    logic [4:0]  rd_reg_o;
    logic        rd_done_i = 1'b0;
    logic [15:0] rd_data_i = 16'h0;
    logic        busy_o, done_o, found_o;
    logic [4:0]  phy_addr_o;
    logic [15:0] id1_o, id2_o;
    logic [1:0]  kind_o;

    phy_scan_top dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_phy_o(rd_phy_o), .rd_reg_o(rd_reg_o),
        .rd_done_i(rd_done_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
        .phy_addr_o(phy_addr_o), .id1_o(id1_o), .id2_o(id2_o), .kind_o(kind_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Bus model state
    logic [15:0] t1 [32];
    logic [15:0] t2 [32];
    int lat = 0;
    int cnt = 0;
    int reads = 0;
    int order_err = 0;
    int exp_phy = 0;
    bit second = 0;

    // Expected results
    bit          e_found;
    logic [4:0]  e_addr;
    logic [1:0]  e_kind;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // MDIO master model, driven away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            rd_done_i = 1'b0;
            cnt = lat;
        end else if (rd_done_i) begin
            rd_done_i = 1'b0;
            cnt = lat;
        end else if (rd_req_o) begin
            if (cnt == 0) begin
                rd_done_i = 1'b1;
                if (rd_reg_o == 5'd2)      rd_data_i = t1[rd_phy_o];
                else if (rd_reg_o == 5'd3) rd_data_i = t2[rd_phy_o];
                else                       rd_data_i = 16'hDEAD;
                if ((rd_reg_o != (second ? 5'd3 : 5'd2)) || (int'(rd_phy_o) != exp_phy))
                    order_err++;
                if (second) exp_phy++;
                second = !second;
                reads++;
            end else begin
                cnt--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit word_good(input logic [15:0] w);
        return (w >= 16'h0001) && (w <= 16'hFFFE) && (w != 16'h8000);
    endfunction

    task automatic compute_ref();
        e_found = 0; e_addr = 0; e_kind = 0;
        for (int a = 0; a < 32; a++) begin
            if (!e_found && word_good(t1[a]) && word_good(t2[a])) begin
                e_found = 1;
                e_addr  = 5'(a);
                if (t1[a] == 16'h0016 && t2[a][15:4] == 12'hF84)      e_kind = 2'd1;
                else if (t1[a] == 16'h0282 && t2[a][15:4] == 12'h1C5) e_kind = 2'd2;
                else                                                  e_kind = 2'd3;
            end
        end
    endtask

    task automatic fill(input logic [15:0] v1, input logic [15:0] v2);
        for (int a = 0; a < 32; a++) begin
            t1[a] = v1;
            t2[a] = v2;
        end
    endtask

    // Runs one search; restart_at > 0 pulses start again mid-search.
    task automatic run_scan(input string req, input int restart_at);
        int waited;
        int exp_reads;
        logic [15:0] h1, h2;
        compute_ref();
        exp_reads = e_found ? 2 * (int'(e_addr) + 1) : 64;
        @(negedge clk);
        reads = 0; order_err = 0; exp_phy = 0; second = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (restart_at > 0 && waited == restart_at) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, req, "done seen", done_o, 1);
        chk(busy_o == 1'b0, "R9", "busy low with done", busy_o, 0);
        chk(found_o == e_found, req, "found", found_o, e_found);
        chk(phy_addr_o == e_addr, "R1", "address", phy_addr_o, e_addr);
        chk(kind_o == e_kind, req, "kind", kind_o, e_kind);
        h1 = e_found ? t1[e_addr] : 16'h0;
        h2 = e_found ? t2[e_addr] : 16'h0;
        chk(id1_o == h1, req, "id1", id1_o, h1);
        chk(id2_o == h2, req, "id2", id2_o, h2);
        chk(reads == exp_reads, "R1", "read count", reads, exp_reads);
        chk(order_err == 0, "R2", "read order errors", order_err, 0);
        // R9: done is one cycle and result holds
        @(negedge clk);
        chk(done_o == 1'b0, "R9", "done pulse width", done_o, 0);
        repeat (20) @(negedge clk);
        chk(found_o == e_found && phy_addr_o == e_addr && kind_o == e_kind && id1_o == h1,
            "R9", "result held", {found_o, phy_addr_o, kind_o}, {e_found, e_addr, e_kind});
        chk(rd_req_o == 1'b0, "R8", "no request while idle", rd_req_o, 0);
    endtask

    task automatic t_reset();
        chk(busy_o == 0 && done_o == 0 && found_o == 0 && rd_req_o == 0, "R10",
            "control after reset", {busy_o, done_o, found_o, rd_req_o}, 0);
        chk(phy_addr_o == 0 && id1_o == 0 && id2_o == 0 && kind_o == 0, "R10",
            "result after reset", {phy_addr_o, id1_o, id2_o, kind_o}, 0);
    endtask

    task automatic t_empty_bus();
        lat = 2;
        fill(16'hFFFF, 16'hFFFF);
        run_scan("R5", 0);
    endtask

    task automatic t_rejects_then_alpha();
        lat = 0;
        fill(16'h0000, 16'h0000);       // R3: zero words at addr 0,1
        t1[1] = 16'h1234;               // only second word blank
        t1[2] = 16'h8000; t2[2] = 16'h1234; // R4: stuck in first word
        t1[3] = 16'h1234; t2[3] = 16'h8000; // R4: stuck in second word
        t1[4] = 16'h1234; t2[4] = 16'hFFFF; // R3: second word floats
        t1[5] = 16'h0016; t2[5] = 16'hF84B; // R6
        t1[7] = 16'h0282; t2[7] = 16'h1C50;
        run_scan("R6", 0);
    endtask

    task automatic t_beta_last();
        lat = 1;
        fill(16'hFFFF, 16'h0000);
        t1[31] = 16'h0282; t2[31] = 16'h1C5A; // R7 at highest address
        run_scan("R7", 0);
    endtask

    task automatic t_other_masks();
        lat = 0;
        fill(16'hFFFF, 16'hFFFF);
        t1[0] = 16'h0016; t2[0] = 16'hF850;   // R7: mask mismatch -> other
        run_scan("R7", 0);
        t1[0] = 16'hFFFF;
        t1[6] = 16'h0017; t2[6] = 16'hF840;   // R7: id1 mismatch -> other
        run_scan("R7", 0);
    endtask

    task automatic t_two_valid();
        lat = 3;
        fill(16'h0000, 16'hFFFF);
        t1[9]  = 16'h0282; t2[9]  = 16'h1C51; // R1: lower wins
        t1[12] = 16'h0016; t2[12] = 16'hF840;
        run_scan("R1", 0);
    endtask

    task automatic t_boundaries();
        lat = 0;
        fill(16'hFFFF, 16'hFFFF);
        t1[2] = 16'h8001; t2[2] = 16'h8000;   // R4 reject
        t1[3] = 16'h0001; t2[3] = 16'hFFFE;   // R3 accept edges
        run_scan("R3", 0);
        t1[3] = 16'h7FFF; t2[3] = 16'h8001;   // R4: neighbours of stuck value pass
        run_scan("R4", 0);
    endtask

    task automatic t_restart_ignored();
        lat = 4;
        fill(16'h0000, 16'h0000);
        t1[20] = 16'h0016; t2[20] = 16'hF841;
        run_scan("R9", 40);                   // R9: second start mid-search ignored
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_empty_bus();
        t_rejects_then_alpha();
        t_beta_last();
        t_other_masks();
        t_two_valid();
        t_boundaries();
        t_restart_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule